// File: doc/BRIEF.md
# Two-Wire Master Status Flag Unit

This block holds the read-only status word of a two-wire (I2C-style) bus master. The byte engine does not report its progress directly to software. It sends single-cycle event strobes instead: the master was enabled, the holding register was written, a byte moved into the shifter, the transmit path is empty, a STOP went out, a byte was received, or the slave failed to acknowledge. The unit turns these strobes into five sticky flags with their own set and clear rules, and places them at fixed bit positions in a 32-bit word.

Two bus-side strobes clear flags. A read of the receive holding register clears the receive-ready flag. A read of the status word clears the acknowledge-failure flag, and clears the overrun flag only when transmission is complete at that moment. A read always returns the flag values held before the read, and a clear takes effect on the following cycle. If a set and a clear for the same flag arrive in the same cycle, the set wins, so no event is lost.

Top module: `tw_status_flags`

## Requirements
- R1: The status word has transmission-complete at bit 0, receive-ready at bit 1, transmit-ready at bit 2, overrun at bit 6 and acknowledge-failure at bit 8. Every other bit reads 0.
- R2: Synchronous reset clears all flags. All flags stay 0 until the first master-enable strobe, whatever other strobes arrive before it.
- R3: A master-enable strobe sets transmission-complete and transmit-ready on the next cycle.
- R4: Transmission-complete clears after a holding-register write or a received-byte strobe. It sets after a cycle in which the transmit path is empty and a STOP was sent.
- R5: Receive-ready sets after a received-byte strobe and clears after a receive holding register read.
- R6: Transmit-ready clears after a holding-register write and sets again after a byte-to-shifter strobe.
- R7: An acknowledge-failure strobe sets acknowledge-failure, transmit-ready and transmission-complete together on the next cycle.
- R8: A status read clears acknowledge-failure on the next cycle.
- R9: Overrun sets after a received-byte strobe that arrives while receive-ready is already 1. This applies only while master mode is 1.
- R10: A status read clears overrun only if transmission-complete is 1 in the read cycle. Otherwise overrun holds.
- R11: A status read sees the pre-read flag values. A set and a clear for the same flag in one cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Master enable strobe |
| thr_write | input | 1 | Transmit holding register written |
| byte_to_shifter | input | 1 | Held byte moved into the shifter |
| tx_all_empty | input | 1 | Holding register and shifter both empty |
| stop_done | input | 1 | STOP condition sent |
| rx_byte_loaded | input | 1 | Byte loaded into receive holding register |
| nack_seen | input | 1 | Slave did not acknowledge a data byte |
| master_mode | input | 1 | Controller is in master mode |
| rhr_read | input | 1 | Receive holding register read strobe |
| status_read | input | 1 | Status word read strobe |
| status_word | output | 32 | Status word |

## Verification
Every flag is a single register, and the word is wired straight from those registers. A strobe applied in one cycle therefore shows in the word one cycle later, and a status read shows the old value during its own cycle. The bench drives inputs just after a rising edge. It updates its reference model at the next edge and compares the whole word shortly after that edge on every cycle, so each result is checked in the cycle it is due. Directed phases cover pre-enable strobes, set/clear collisions, overrun outside master mode and a read with transmission incomplete. A pseudo-random stretch then mixes all strobes.

// File: rtl/tw_stat_pkg.sv
package tw_stat_pkg;

    localparam int unsigned SW_W   = 32;
    localparam int unsigned NFLAG  = 5;

    // flag indices inside the internal flag vector
    localparam int unsigned F_TXCOMP = 0;
    localparam int unsigned F_RXRDY  = 1;
    localparam int unsigned F_TXRDY  = 2;
    localparam int unsigned F_OVRE   = 3;
    localparam int unsigned F_NACK   = 4;

    // bit positions in the visible status word
    localparam int unsigned POS_TXCOMP = 0;
    localparam int unsigned POS_RXRDY  = 1;
    localparam int unsigned POS_TXRDY  = 2;
    localparam int unsigned POS_OVRE   = 6;
    localparam int unsigned POS_NACK   = 8;

    typedef struct packed {
        logic nack;
        logic ovre;
        logic txrdy;
        logic rxrdy;
        logic txcomp;
    } flags_t;

    typedef struct packed {
        logic enable;
        logic thr_wr;
        logic shift_ld;
        logic tx_empty;
        logic stop_sent;
        logic rx_load;
        logic nack;
        logic master;
        logic rhr_rd;
        logic sr_rd;
    } evt_t;

    function automatic logic [SW_W-1:0] pack_word(input flags_t f);
        logic [SW_W-1:0] w;
        w = '0;
        w[POS_TXCOMP] = f.txcomp;
        w[POS_RXRDY]  = f.rxrdy;
        w[POS_TXRDY]  = f.txrdy;
        w[POS_OVRE]   = f.ovre;
        w[POS_NACK]   = f.nack;
        return w;
    endfunction

    function automatic logic [SW_W-1:0] used_mask();
        flags_t all_on;
        all_on = '1;
        return pack_word(all_on);
    endfunction

endpackage

// File: rtl/tw_stat_cell.sv
module tw_stat_cell
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // set has priority over clear so a coincident event is kept
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/tw_stat_arm.sv
module tw_stat_arm
(
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    output logic armed_o
);
    always_ff @(posedge clk) begin
        if (rst)           armed_o <= 1'b0;
        else if (enable_i) armed_o <= 1'b1;
    end
endmodule

// File: rtl/tw_stat_rules.sv
module tw_stat_rules
    import tw_stat_pkg::*;
(
    input  evt_t              evt_i,
    input  logic              armed_i,
    input  logic              txcomp_i,
    input  logic              rxrdy_i,
    output logic [NFLAG-1:0]  set_o,
    output logic [NFLAG-1:0]  clr_o
);
    logic live;
    logic [NFLAG-1:0] raw_set;

    assign live = armed_i | evt_i.enable;

    always_comb begin
        raw_set = '0;
        clr_o   = '0;

        raw_set[F_TXCOMP] = evt_i.enable | evt_i.nack
                          | (evt_i.tx_empty & evt_i.stop_sent);
        clr_o[F_TXCOMP]   = evt_i.thr_wr | evt_i.rx_load;

        raw_set[F_RXRDY]  = evt_i.rx_load;
        clr_o[F_RXRDY]    = evt_i.rhr_rd;

        raw_set[F_TXRDY]  = evt_i.enable | evt_i.shift_ld | evt_i.nack;
        clr_o[F_TXRDY]    = evt_i.thr_wr;

        raw_set[F_OVRE]   = evt_i.rx_load & rxrdy_i & evt_i.master;
        clr_o[F_OVRE]     = evt_i.sr_rd & txcomp_i;

        raw_set[F_NACK]   = evt_i.nack;
        clr_o[F_NACK]     = evt_i.sr_rd;

        set_o = raw_set & {NFLAG{live}};
    end
endmodule

// File: rtl/tw_status_flags.sv
module tw_status_flags
    import tw_stat_pkg::*;
#(
    parameter int unsigned WORD_W = SW_W
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              thr_write,
    input  logic              byte_to_shifter,
    input  logic              tx_all_empty,
    input  logic              stop_done,
    input  logic              rx_byte_loaded,
    input  logic              nack_seen,
    input  logic              master_mode,
    input  logic              rhr_read,
    input  logic              status_read,
    output logic [WORD_W-1:0] status_word
);
    localparam int unsigned PAD_W = (WORD_W > SW_W) ? WORD_W - SW_W : 1;

    evt_t              evt;
    flags_t            cur;
    logic [NFLAG-1:0]  flag_q;
    logic [NFLAG-1:0]  set_v;
    logic [NFLAG-1:0]  clr_v;
    logic              armed_q;
    logic [SW_W-1:0]   packed_w;

    always_comb begin
        evt.enable    = master_en;
        evt.thr_wr    = thr_write;
        evt.shift_ld  = byte_to_shifter;
        evt.tx_empty  = tx_all_empty;
        evt.stop_sent = stop_done;
        evt.rx_load   = rx_byte_loaded;
        evt.nack      = nack_seen;
        evt.master    = master_mode;
        evt.rhr_rd    = rhr_read;
        evt.sr_rd     = status_read;
    end

    tw_stat_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .enable_i (master_en),
        .armed_o  (armed_q)
    );

    tw_stat_rules u_rules (
        .evt_i    (evt),
        .armed_i  (armed_q),
        .txcomp_i (cur.txcomp),
        .rxrdy_i  (cur.rxrdy),
        .set_o    (set_v),
        .clr_o    (clr_v)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        tw_stat_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (flag_q[i])
        );
    end

    assign cur      = flags_t'(flag_q);
    assign packed_w = pack_word(cur);

    if (WORD_W > SW_W) begin : g_wide
        assign status_word = {{PAD_W{1'b0}}, packed_w};
    end else begin : g_fit
        assign status_word = packed_w[WORD_W-1:0];
    end
endmodule

// File: rtl/tw_status_flags_chk.sv
module tw_status_flags_chk
    import tw_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            armed,
    input  logic            master_en,
    input  logic            thr_write,
    input  logic            byte_to_shifter,
    input  logic            rx_byte_loaded,
    input  logic            nack_seen,
    input  logic            rhr_read,
    input  logic            status_read,
    input  logic [SW_W-1:0] status_word
);
    localparam logic [SW_W-1:0] MASK = used_mask();

    assert_spare_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (status_word & ~MASK) == '0);

    assert_quiet_before_enable_R2: assert property (@(posedge clk) disable iff (rst)
        !armed |-> status_word == '0);

    assert_enable_presets_R3: assert property (@(posedge clk) disable iff (rst)
        master_en |=> (status_word[POS_TXCOMP] && status_word[POS_TXRDY]));

    assert_thr_clears_txrdy_R6: assert property (@(posedge clk) disable iff (rst)
        (thr_write && !byte_to_shifter && !master_en && !nack_seen)
        |=> !status_word[POS_TXRDY]);

    assert_nack_triple_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[POS_NACK])
        |-> (status_word[POS_TXCOMP] && status_word[POS_TXRDY]));

    assert_read_clears_nack_R8: assert property (@(posedge clk) disable iff (rst)
        (status_read && !nack_seen) |=> !status_word[POS_NACK]);

    assert_ovre_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (status_read && !status_word[POS_TXCOMP] && status_word[POS_OVRE])
        |=> status_word[POS_OVRE]);

    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_byte_loaded && rhr_read && (armed || master_en))
        |=> status_word[POS_RXRDY]);
endmodule

bind tw_status_flags tw_status_flags_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .armed           (armed_q),
    .master_en       (master_en),
    .thr_write       (thr_write),
    .byte_to_shifter (byte_to_shifter),
    .rx_byte_loaded  (rx_byte_loaded),
    .nack_seen       (nack_seen),
    .rhr_read        (rhr_read),
    .status_read     (status_read),
    .status_word     (status_word)
);

// File: tb/tb_tw_status_flags.sv
module tb_tw_status_flags;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, thr = 0, shl = 0, emp = 0, stp = 0;
    logic rxl = 0, nk = 0, mm = 0, rhr = 0, sr = 0;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    bit m_tc, m_rr, m_tr, m_ov, m_nk, m_arm;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_status_flags dut (
        .clk             (clk),
        .rst             (rst),
        .master_en       (en),
        .thr_write       (thr),
        .byte_to_shifter (shl),
        .tx_all_empty    (emp),
        .stop_done       (stp),
        .rx_byte_loaded  (rxl),
        .nack_seen       (nk),
        .master_mode     (mm),
        .rhr_read        (rhr),
        .status_read     (sr),
        .status_word     (status_word)
    );

    function automatic logic [31:0] model_word();
        logic [31:0] w = 32'd0;
        if (m_tc) w = w | 32'h001;
        if (m_rr) w = w | 32'h002;
        if (m_tr) w = w | 32'h004;
        if (m_ov) w = w | 32'h040;
        if (m_nk) w = w | 32'h100;
        return w;
    endfunction

    task automatic model_step();
        bit ok, n_tc, n_rr, n_tr, n_ov, n_nk;
        if (rst) begin
            m_tc = 0; m_rr = 0; m_tr = 0; m_ov = 0; m_nk = 0; m_arm = 0;
            return;
        end
        ok = m_arm || en;
        n_tc = m_tc; n_rr = m_rr; n_tr = m_tr; n_ov = m_ov; n_nk = m_nk;
        if (thr || rxl) n_tc = 0;
        if (ok && (en || nk || (emp && stp))) n_tc = 1;
        if (rhr) n_rr = 0;
        if (ok && rxl) n_rr = 1;
        if (thr) n_tr = 0;
        if (ok && (en || shl || nk)) n_tr = 1;
        if (sr && m_tc) n_ov = 0;
        if (ok && rxl && m_rr && mm) n_ov = 1;
        if (sr) n_nk = 0;
        if (ok && nk) n_nk = 1;
        m_tc = n_tc; m_rr = n_rr; m_tr = n_tr; m_ov = n_ov; m_nk = n_nk;
        if (en) m_arm = 1;
    endtask

    task automatic compare(input string tag);
        logic [31:0] exp_w = model_word();
        checks++;
        if (status_word !== exp_w) begin
            errors++;
            $display("FAIL %s: status_word=%h expected=%h at %0t", tag, status_word, exp_w, $time);
        end
    endtask

    task automatic idle_inputs();
        en = 0; thr = 0; shl = 0; emp = 0; stp = 0;
        rxl = 0; nk = 0; rhr = 0; sr = 0;
    endtask

    // one clock: model follows the edge, word compared 1 time unit later, strobes dropped
    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1;
        tick("R2");
        tick("R2");
        rst = 0;
        tick("R2");

        // R2: strobes before enable are ignored
        rxl = 1; nk = 1; shl = 1; emp = 1; stp = 1; mm = 1; tick("R2");
        rxl = 1; mm = 1; tick("R2");
        tick("R2");

        // R3
        en = 1; tick("R3");
        tick("R1");

        // R6 / R4: write, then move to shifter
        thr = 1; tick("R6");
        shl = 1; tick("R6");
        emp = 1; tick("R4");
        emp = 1; stp = 1; tick("R4");

        // R5 / R9: receive bytes in master mode
        mm = 1;
        rxl = 1; tick("R5");
        rxl = 1; tick("R9");
        // R10: read with txcomp low keeps overrun
        sr = 1; tick("R10");
        tick("R10");
        rhr = 1; tick("R5");
        emp = 1; stp = 1; tick("R4");
        sr = 1; tick("R10");
        tick("R10");

        // R9: outside master mode no overrun
        mm = 0;
        rxl = 1; tick("R9");
        rxl = 1; tick("R9");
        rhr = 1; tick("R5");

        // R7 / R8
        thr = 1; tick("R6");
        nk = 1; tick("R7");
        sr = 1; tick("R8");
        tick("R8");

        // R11: coincident set and clear
        rxl = 1; rhr = 1; tick("R11");
        nk = 1; sr = 1; tick("R11");
        thr = 1; shl = 1; tick("R11");
        sr = 1; tick("R11");
        rhr = 1; tick("R11");

        // mixed stretch
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en  = (lfsr[3:0] == 4'h0) && (lfsr[9:8] == 2'b11);
            thr = lfsr[1] & lfsr[4];
            shl = lfsr[2];
            emp = lfsr[5];
            stp = lfsr[6] | lfsr[0];
            rxl = lfsr[7] & lfsr[3];
            nk  = (lfsr[11:9] == 3'b101);
            mm  = ~lfsr[12] | lfsr[13];
            rhr = lfsr[14] & lfsr[2];
            sr  = lfsr[15] ^ lfsr[8];
            if (i == 300) rst = 1;
            if (i == 302) rst = 0;
            tick("R1");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule